// File: doc/BRIEF.md
# Unfused Negative Multiply-Add Unit

This block computes `-((fs × ft) + fr)` on IEEE-754 binary32 values. It is not fused: the product is rounded to binary32 first. That rounded product is then added to the addend `fr`, and the sum is rounded a second time. The final negation is a plain sign flip applied after the last rounding. Results and flags therefore match a separate multiply, add and negate sequence.

A paired mode treats each 64-bit operand word as two independent binary32 lanes. The lanes' exception causes are ORed together. In single mode only the low lane is used.

The unit is a two-stage pipeline and accepts a new operation on every cycle. Each result comes with a done pulse and five cause bits. Per-cause trap enables decide whether the causes merge into sticky flags or whether a trap pulse is raised instead. Subnormal operands are flushed to zero. A result that would be subnormal is reported as unimplemented instead of being produced.

Top module: `fp_nmadd_unit`

## Requirements
- R1: Every `start_i` produces exactly one `done_o` pulse two clock edges later, carrying `-((fs × ft) + fr)` for that operation. A new operation may start on every cycle.
- R2: The product is rounded to binary32 with the selected mode before the addition. For example, (1+2^-23)² added to -(1+2^-22) gives `0x80000000` in mode 0, with inexact set.
- R3: Rounding mode encoding on `rm_i` is 0 = nearest-even, 1 = toward zero, 2 = toward +infinity, 3 = toward -infinity. The mode applies to both roundings.
- R4: An exact zero sum of opposite-signed terms is +0 before negation, or -0 in mode 3. The sign flip then yields `0x80000000` or `0x00000000`.
- R5: Overflow sets the overflow and inexact causes. The pre-negation result is infinity or the largest finite value, as the mode directs.
- R6: Any NaN operand, infinity times zero, or a sum of opposite infinities yields `0x7FC00000`, not sign-flipped, with the invalid cause set.
- R7: Operands with a zero exponent field count as signed zero. A product or sum whose biased exponent falls to zero or below becomes a signed zero and sets the unimplemented and underflow causes.
- R8: With `pair_i`=1, bits [63:32] and [31:0] are computed independently and their causes are ORed. With `pair_i`=0, only the low lane is used, `result_o[63:32]` is zero and the high lane raises no cause.
- R9: Cause bits are: bit0 inexact, bit1 underflow, bit2 overflow, bit3 invalid, bit4 unimplemented. `flags_o` accumulates the causes by OR only when no enabled cause is present, and it never clears outside reset.
- R10: When `cause & trap_en_i` (trap enables sampled with `start_i`) is nonzero, `trap_o` pulses together with `done_o` and `flags_o` is left unchanged.
- R11: After reset, `done_o`, `trap_o`, `result_o`, `cause_o` and `flags_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Begin an operation with the current operands |
| pair_i | input | 1 | 1 = two packed lanes, 0 = low lane only |
| rm_i | input | 2 | Rounding mode |
| trap_en_i | input | 5 | Per-cause trap enables |
| fs_i | input | 64 | First multiplicand |
| ft_i | input | 64 | Second multiplicand |
| fr_i | input | 64 | Addend |
| result_o | output | 64 | Negated rounded result |
| done_o | output | 1 | Result valid pulse |
| cause_o | output | 5 | Causes of the last completed operation |
| trap_o | output | 1 | Enabled cause present, pulses with done |
| flags_o | output | 5 | Sticky accumulated causes |

## Verification
The bench targets the case where unfused and fused results differ. A design that skipped the product rounding would return a tiny nonzero value instead of a zero. It also covers the signed-zero rule of an exact cancellation: a design that negated before rounding, or ignored mode 3, would return the zero with the wrong sign. Ties and overflow are driven in each rounding direction; a wrong increment or saturation rule shows up as an off-by-one ulp or as infinity in place of the largest finite value. Further cases are a poisoned high lane in single mode, mixed lanes in paired mode, and an enabled trap. These catch lane leakage, lost ORing of causes, and flags updated despite a trap.

// File: rtl/fnm_pkg.sv
package fnm_pkg;
    localparam int EXP_W  = 8;
    localparam int MAN_W  = 23;
    localparam int WORD_W = 1 + EXP_W + MAN_W;
    localparam int SIG_W  = MAN_W + 1;
    localparam int EXT_W  = SIG_W + 3;
    localparam int CAUSE_W = 5;
    localparam int C_INX = 0;
    localparam int C_UNF = 1;
    localparam int C_OVF = 2;
    localparam int C_INV = 3;
    localparam int C_UNI = 4;
    localparam logic [WORD_W-1:0] QNAN = 32'h7FC0_0000;
    localparam logic [EXP_W-1:0] EXP_MAX = '1;

    typedef enum logic [1:0] {
        RM_NE = 2'd0,
        RM_TZ = 2'd1,
        RM_UP = 2'd2,
        RM_DN = 2'd3
    } rmode_e;

    function automatic logic [4:0] lead_zeros(input logic [EXT_W-1:0] v);
        logic [4:0] n;
        logic hit;
        n = 5'd0;
        hit = 1'b0;
        for (int i = EXT_W - 1; i >= 0; i--) begin
            if (!hit) begin
                if (v[i]) hit = 1'b1;
                else n = n + 5'd1;
            end
        end
        return n;
    endfunction
endpackage

// File: rtl/fnm_round.sv
module fnm_round
    import fnm_pkg::*;
(
    input  logic                    sgn_i,
    input  logic signed [9:0]       exp_i,
    input  logic [SIG_W-1:0]        sig_i,
    input  logic                    grd_i,
    input  logic                    stk_i,
    input  rmode_e                  rm_i,
    output logic [WORD_W-1:0]       word_o,
    output logic [CAUSE_W-1:0]      cause_o
);
    logic              inx_w;
    logic              inc_w;
    logic              big_w;
    logic [SIG_W:0]    sum_w;
    logic [SIG_W-1:0]  sig_r;
    logic signed [9:0] exp_r;

    always_comb begin
        inx_w = grd_i | stk_i;
        unique case (rm_i)
            RM_NE:   inc_w = grd_i & (stk_i | sig_i[0]);
            RM_TZ:   inc_w = 1'b0;
            RM_UP:   inc_w = ~sgn_i & inx_w;
            default: inc_w = sgn_i & inx_w;
        endcase
        sum_w = {1'b0, sig_i} + {{SIG_W{1'b0}}, inc_w};
        if (sum_w[SIG_W]) begin
            sig_r = sum_w[SIG_W:1];
            exp_r = exp_i + 10'sd1;
        end else begin
            sig_r = sum_w[SIG_W-1:0];
            exp_r = exp_i;
        end
        big_w = (rm_i == RM_NE) || (rm_i == RM_UP && !sgn_i) || (rm_i == RM_DN && sgn_i);
        cause_o = '0;
        if (exp_i <= 10'sd0) begin
            word_o = {sgn_i, {(WORD_W-1){1'b0}}};
            cause_o[C_UNI] = 1'b1;
            cause_o[C_UNF] = 1'b1;
        end else if (exp_r >= 10'sd255) begin
            word_o = big_w ? {sgn_i, EXP_MAX, {MAN_W{1'b0}}}
                           : {sgn_i, EXP_MAX - 8'd1, {MAN_W{1'b1}}};
            cause_o[C_OVF] = 1'b1;
            cause_o[C_INX] = 1'b1;
        end else begin
            word_o = {sgn_i, exp_r[EXP_W-1:0], sig_r[MAN_W-1:0]};
            cause_o[C_INX] = inx_w;
        end
    end
endmodule

// File: rtl/fnm_mul_lane.sv
module fnm_mul_lane
    import fnm_pkg::*;
(
    input  logic [WORD_W-1:0]  a_i,
    input  logic [WORD_W-1:0]  b_i,
    input  rmode_e             rm_i,
    output logic [WORD_W-1:0]  prod_o,
    output logic [CAUSE_W-1:0] cause_o,
    output logic               inv_o
);
    localparam int P_W = 2 * SIG_W;

    logic a_zero, b_zero, a_inf, b_inf, a_nan, b_nan, sgn;
    logic [P_W-1:0]   pfull;
    logic signed [9:0] ex0, ex1;
    logic [SIG_W-1:0] sig;
    logic grd, stk;
    logic [WORD_W-1:0]  rw;
    logic [CAUSE_W-1:0] rc;

    always_comb begin
        a_zero = a_i[30:23] == '0;
        b_zero = b_i[30:23] == '0;
        a_inf  = a_i[30:23] == EXP_MAX && a_i[22:0] == '0;
        b_inf  = b_i[30:23] == EXP_MAX && b_i[22:0] == '0;
        a_nan  = a_i[30:23] == EXP_MAX && a_i[22:0] != '0;
        b_nan  = b_i[30:23] == EXP_MAX && b_i[22:0] != '0;
        sgn    = a_i[31] ^ b_i[31];
        pfull  = P_W'({1'b1, a_i[22:0]}) * P_W'({1'b1, b_i[22:0]});
        ex0    = $signed({2'b00, a_i[30:23]}) + $signed({2'b00, b_i[30:23]}) - 10'sd127;
        if (pfull[P_W-1]) begin
            sig = pfull[P_W-1 -: SIG_W];
            grd = pfull[P_W-1-SIG_W];
            stk = |pfull[P_W-2-SIG_W:0];
            ex1 = ex0 + 10'sd1;
        end else begin
            sig = pfull[P_W-2 -: SIG_W];
            grd = pfull[P_W-2-SIG_W];
            stk = |pfull[P_W-3-SIG_W:0];
            ex1 = ex0;
        end
    end

    fnm_round u_rnd (
        .sgn_i  (sgn),
        .exp_i  (ex1),
        .sig_i  (sig),
        .grd_i  (grd),
        .stk_i  (stk),
        .rm_i   (rm_i),
        .word_o (rw),
        .cause_o(rc)
    );

    always_comb begin
        inv_o   = 1'b0;
        cause_o = '0;
        if (a_nan || b_nan || (a_inf && b_zero) || (b_inf && a_zero)) begin
            inv_o  = 1'b1;
            prod_o = QNAN;
        end else if (a_inf || b_inf) begin
            prod_o = {sgn, EXP_MAX, {MAN_W{1'b0}}};
        end else if (a_zero || b_zero) begin
            prod_o = {sgn, {(WORD_W-1){1'b0}}};
        end else begin
            prod_o  = rw;
            cause_o = rc;
        end
    end
endmodule

// File: rtl/fnm_add_lane.sv
module fnm_add_lane
    import fnm_pkg::*;
(
    input  logic [WORD_W-1:0]  x_i,
    input  logic [WORD_W-1:0]  c_i,
    input  logic               mul_inv_i,
    input  rmode_e             rm_i,
    output logic [WORD_W-1:0]  res_o,
    output logic [CAUSE_W-1:0] cause_o
);
    logic x_zero, c_zero, x_inf, c_inf, c_nan, x_big, eff_sub, zs;
    logic [WORD_W-1:0]  bw, sw;
    logic [EXP_W-1:0]   d;
    logic [EXT_W-1:0]   big_f, small_f, sm, mask, diff, norm;
    logic [EXT_W:0]     sum_f;
    logic [4:0]         lz;
    logic signed [9:0]  nexp;
    logic [WORD_W-1:0]  rw;
    logic [CAUSE_W-1:0] rc;

    always_comb begin
        x_zero  = x_i[30:23] == '0;
        c_zero  = c_i[30:23] == '0;
        x_inf   = x_i[30:23] == EXP_MAX;
        c_inf   = c_i[30:23] == EXP_MAX && c_i[22:0] == '0;
        c_nan   = c_i[30:23] == EXP_MAX && c_i[22:0] != '0;
        x_big   = x_i[30:0] >= c_i[30:0];
        bw      = x_big ? x_i : c_i;
        sw      = x_big ? c_i : x_i;
        eff_sub = x_i[31] ^ c_i[31];
        d       = bw[30:23] - sw[30:23];
        big_f   = {1'b1, bw[22:0], 3'b000};
        small_f = {1'b1, sw[22:0], 3'b000};
        mask    = '0;
        if (d >= 8'd27) begin
            sm = {{(EXT_W-1){1'b0}}, 1'b1};
        end else begin
            mask = (EXT_W'(1) << d) - EXT_W'(1);
            sm   = (small_f >> d) | {{(EXT_W-1){1'b0}}, |(small_f & mask)};
        end
        sum_f = {1'b0, big_f} + {1'b0, sm};
        diff  = big_f - sm;
        lz    = lead_zeros(diff);
        if (eff_sub) begin
            norm = diff << lz;
            nexp = $signed({2'b00, bw[30:23]}) - $signed({5'd0, lz});
        end else if (sum_f[EXT_W]) begin
            norm = {sum_f[EXT_W:2], sum_f[1] | sum_f[0]};
            nexp = $signed({2'b00, bw[30:23]}) + 10'sd1;
        end else begin
            norm = sum_f[EXT_W-1:0];
            nexp = $signed({2'b00, bw[30:23]});
        end
        zs = (rm_i == RM_DN);
    end

    fnm_round u_rnd (
        .sgn_i  (bw[31]),
        .exp_i  (nexp),
        .sig_i  (norm[EXT_W-1 -: SIG_W]),
        .grd_i  (norm[2]),
        .stk_i  (|norm[1:0]),
        .rm_i   (rm_i),
        .word_o (rw),
        .cause_o(rc)
    );

    always_comb begin
        cause_o = '0;
        if (mul_inv_i || c_nan || (x_inf && c_inf && eff_sub)) begin
            res_o = QNAN;
            cause_o[C_INV] = 1'b1;
        end else if (x_inf) begin
            res_o = {~x_i[31], x_i[30:0]};
        end else if (c_inf) begin
            res_o = {~c_i[31], c_i[30:0]};
        end else if (x_zero && c_zero) begin
            res_o = {~(eff_sub ? zs : x_i[31]), {(WORD_W-1){1'b0}}};
        end else if (x_zero) begin
            res_o = {~c_i[31], c_i[30:0]};
        end else if (c_zero) begin
            res_o = {~x_i[31], x_i[30:0]};
        end else if (eff_sub && diff == '0) begin
            res_o = {~zs, {(WORD_W-1){1'b0}}};
        end else begin
            res_o   = {~rw[31], rw[30:0]};
            cause_o = rc;
        end
    end
endmodule

// File: rtl/fp_nmadd_unit.sv
module fp_nmadd_unit
    import fnm_pkg::*;
#(
    parameter int LANES = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start_i,
    input  logic                    pair_i,
    input  logic [1:0]              rm_i,
    input  logic [CAUSE_W-1:0]      trap_en_i,
    input  logic [LANES*WORD_W-1:0] fs_i,
    input  logic [LANES*WORD_W-1:0] ft_i,
    input  logic [LANES*WORD_W-1:0] fr_i,
    output logic [LANES*WORD_W-1:0] result_o,
    output logic                    done_o,
    output logic [CAUSE_W-1:0]      cause_o,
    output logic                    trap_o,
    output logic [CAUSE_W-1:0]      flags_o
);
    localparam int W = LANES * WORD_W;

    typedef struct packed {
        logic                            s1_vld;
        logic                            s1_pair;
        rmode_e                          s1_rm;
        logic [CAUSE_W-1:0]              s1_en;
        logic [LANES-1:0][WORD_W-1:0]    s1_prod;
        logic [LANES-1:0][CAUSE_W-1:0]   s1_mc;
        logic [LANES-1:0]                s1_minv;
        logic [LANES-1:0][WORD_W-1:0]    s1_c;
        logic                            done;
        logic [W-1:0]                    res;
        logic [CAUSE_W-1:0]              cause;
        logic                            trap;
        logic [CAUSE_W-1:0]              flags;
    } state_t;

    state_t st_q, st_d;

    logic [LANES-1:0][WORD_W-1:0]  prod_w;
    logic [LANES-1:0][CAUSE_W-1:0] mc_w;
    logic [LANES-1:0]              minv_w;
    logic [LANES-1:0][WORD_W-1:0]  sum_w;
    logic [LANES-1:0][CAUSE_W-1:0] ac_w;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        fnm_mul_lane u_mul (
            .a_i    (fs_i[g*WORD_W +: WORD_W]),
            .b_i    (ft_i[g*WORD_W +: WORD_W]),
            .rm_i   (rmode_e'(rm_i)),
            .prod_o (prod_w[g]),
            .cause_o(mc_w[g]),
            .inv_o  (minv_w[g])
        );
        fnm_add_lane u_add (
            .x_i      (st_q.s1_prod[g]),
            .c_i      (st_q.s1_c[g]),
            .mul_inv_i(st_q.s1_minv[g]),
            .rm_i     (st_q.s1_rm),
            .res_o    (sum_w[g]),
            .cause_o  (ac_w[g])
        );
    end

    always_comb begin
        logic [CAUSE_W-1:0] merged;
        st_d   = st_q;
        merged = '0;
        st_d.s1_vld = start_i;
        if (start_i) begin
            st_d.s1_pair = pair_i;
            st_d.s1_rm   = rmode_e'(rm_i);
            st_d.s1_en   = trap_en_i;
            st_d.s1_prod = prod_w;
            st_d.s1_mc   = mc_w;
            st_d.s1_minv = minv_w;
            for (int g = 0; g < LANES; g++) st_d.s1_c[g] = fr_i[g*WORD_W +: WORD_W];
        end
        st_d.done = st_q.s1_vld;
        st_d.trap = 1'b0;
        if (st_q.s1_vld) begin
            for (int g = 0; g < LANES; g++) begin
                if (g == 0 || st_q.s1_pair) begin
                    merged = merged | ac_w[g] | st_q.s1_mc[g];
                    st_d.res[g*WORD_W +: WORD_W] = sum_w[g];
                end else begin
                    st_d.res[g*WORD_W +: WORD_W] = '0;
                end
            end
            st_d.cause = merged;
            st_d.trap  = |(merged & st_q.s1_en);
            if (!st_d.trap) st_d.flags = st_q.flags | merged;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign result_o = st_q.res;
    assign done_o   = st_q.done;
    assign cause_o  = st_q.cause;
    assign trap_o   = st_q.trap;
    assign flags_o  = st_q.flags;

    // R1
    done_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |-> ##2 done_o);

    // R10
    trap_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trap_o |-> done_o);

    // R10
    trap_keeps_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trap_o |-> $stable(flags_o));

    // R9
    flags_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flags_o & $past(flags_o)) == $past(flags_o));

    // R6
    nan_invalid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && result_o[WORD_W-1:0] == QNAN) |-> cause_o[C_INV]);

    // R5
    ovf_inexact_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && cause_o[C_OVF]) |-> cause_o[C_INX]);

    // R8
    single_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !pair_i) |-> ##2 (result_o[W-1:WORD_W] == '0));
endmodule

// File: tb/fp_nmadd_unit_tb_top.sv
module fp_nmadd_unit_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic        pair_i = 1'b0;
    logic [1:0]  rm_i = 2'd0;
    logic [4:0]  trap_en_i = 5'd0;
    logic [63:0] fs_i = '0, ft_i = '0, fr_i = '0;
    logic [63:0] result_o;
    logic        done_o, trap_o;
    logic [4:0]  cause_o, flags_o;

    int checks = 0;
    int fails = 0;
    logic [4:0] model_flags = 5'd0;

    typedef struct {
        logic [63:0] res;
        logic [4:0]  cause;
        logic        trap;
        string       tag;
    } exp_t;
    exp_t sb[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    fp_nmadd_unit dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .pair_i(pair_i),
        .rm_i(rm_i), .trap_en_i(trap_en_i), .fs_i(fs_i), .ft_i(ft_i), .fr_i(fr_i),
        .result_o(result_o), .done_o(done_o), .cause_o(cause_o),
        .trap_o(trap_o), .flags_o(flags_o)
    );

    task automatic issue(input logic [63:0] a, input logic [63:0] b, input logic [63:0] c,
                         input logic pr, input logic [1:0] rm, input logic [4:0] en,
                         input logic [63:0] er, input logic [4:0] ec, input string tag);
        exp_t e;
        @(negedge clk);
        fs_i = a; ft_i = b; fr_i = c; pair_i = pr; rm_i = rm; trap_en_i = en;
        start_i = 1'b1;
        e.res = er; e.cause = ec; e.trap = |(ec & en); e.tag = tag;
        sb.push_back(e);
    endtask

    task automatic single(input logic [31:0] a, input logic [31:0] b, input logic [31:0] c,
                          input logic [1:0] rm, input logic [31:0] er, input logic [4:0] ec,
                          input string tag);
        issue({32'h0, a}, {32'h0, b}, {32'h0, c}, 1'b0, rm, 5'd0, {32'h0, er}, ec, tag);
    endtask

    task automatic idle();
        @(negedge clk);
        start_i = 1'b0;
    endtask

    always @(negedge clk) begin
        if (rst_n && done_o) begin
            checks++;
            if (sb.size() == 0) begin
                fails++;
                $display("FAIL R1 unexpected done: actual result %h expected no done", result_o);
            end else begin
                exp_t e;
                e = sb.pop_front();
                if (!e.trap) model_flags = model_flags | e.cause;
                if (result_o !== e.res || cause_o !== e.cause || trap_o !== e.trap
                    || flags_o !== model_flags) begin
                    fails++;
                    $display("FAIL %s: actual res=%h cause=%b trap=%b flags=%b expected res=%h cause=%b trap=%b flags=%b",
                             e.tag, result_o, cause_o, trap_o, flags_o,
                             e.res, e.cause, e.trap, model_flags);
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual run still busy expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        checks++;
        if (done_o !== 1'b0 || trap_o !== 1'b0 || result_o !== '0 || cause_o !== '0 || flags_o !== '0) begin
            fails++;
            $display("FAIL R11 reset: actual done=%b trap=%b res=%h cause=%b flags=%b expected all zero",
                     done_o, trap_o, result_o, cause_o, flags_o);
        end

        // R1 basic and subtract with renormalise; inf passes through
        single(32'h40000000, 32'h40400000, 32'h3F800000, 2'd0, 32'hC0E00000, 5'h00, "R1 2*3+1");
        single(32'h3F800000, 32'h3FC00000, 32'hBF800000, 2'd0, 32'hBF000000, 5'h00, "R1 1.5-1");
        single(32'h7F800000, 32'h3F800000, 32'h3F800000, 2'd0, 32'hFF800000, 5'h00, "R1 inf+1");
        // R10 trap on inexact: flags stay clear
        issue({32'h0, 32'h3F800001}, {32'h0, 32'h3F800001}, 64'h0, 1'b0, 2'd0, 5'h01,
              {32'h0, 32'hBF800002}, 5'h01, "R10 trap inexact");
        // R2 unfused: rounded product cancels exactly
        single(32'h3F800001, 32'h3F800001, 32'hBF800002, 2'd0, 32'h80000000, 5'h01, "R2 unfused cancel");
        // R3 product rounding in each mode
        single(32'h3F800001, 32'h3F800001, 32'h0, 2'd1, 32'hBF800002, 5'h01, "R3 mul tz");
        single(32'h3F800001, 32'h3F800001, 32'h0, 2'd2, 32'hBF800003, 5'h01, "R3 mul up");
        single(32'h3F800001, 32'h3F800001, 32'h0, 2'd3, 32'hBF800002, 5'h01, "R3 mul dn");
        // R3 sum rounding: tie to even and upward
        single(32'h3F800000, 32'h4B800000, 32'h3F800000, 2'd0, 32'hCB800000, 5'h01, "R3 add tie");
        single(32'h3F800000, 32'h4B800000, 32'h3F800000, 2'd2, 32'hCB800001, 5'h01, "R3 add up");
        // R4 zero signs
        single(32'h40000000, 32'h40400000, 32'hC0C00000, 2'd0, 32'h80000000, 5'h00, "R4 zero ne");
        single(32'h40000000, 32'h40400000, 32'hC0C00000, 2'd3, 32'h00000000, 5'h00, "R4 zero dn");
        // R5 overflow by mode
        single(32'h7F000000, 32'h40000000, 32'h0, 2'd0, 32'hFF800000, 5'h05, "R5 ovf ne");
        single(32'h7F000000, 32'h40000000, 32'h0, 2'd1, 32'hFF7FFFFF, 5'h05, "R5 ovf tz");
        single(32'h7F000000, 32'h40000000, 32'h0, 2'd3, 32'hFF7FFFFF, 5'h05, "R5 ovf dn");
        // R6 invalid cases
        single(32'h7F800000, 32'h00000000, 32'h3F800000, 2'd0, 32'h7FC00000, 5'h08, "R6 inf*0");
        single(32'h3F800000, 32'h3F800000, 32'h7FC00001, 2'd0, 32'h7FC00000, 5'h08, "R6 nan addend");
        single(32'h7F800000, 32'h3F800000, 32'hFF800000, 2'd0, 32'h7FC00000, 5'h08, "R6 inf-inf");
        single(32'h7F800001, 32'h3F800000, 32'h3F800000, 2'd0, 32'h7FC00000, 5'h08, "R6 nan mul");
        // R7 flush and tiny
        single(32'h00000001, 32'h3F800000, 32'h3F800000, 2'd0, 32'hBF800000, 5'h00, "R7 flush in");
        single(32'h00800000, 32'h3F000000, 32'h0, 2'd0, 32'h80000000, 5'h12, "R7 tiny");
        // R8 lanes
        issue({32'h40000000, 32'h7F800000}, {32'h40400000, 32'h0}, {32'h3F800000, 32'h3F800000},
              1'b1, 2'd0, 5'h0, {32'hC0E00000, 32'h7FC00000}, 5'h08, "R8 pair mixed");
        issue({32'h3F800000, 32'h40000000}, {32'h3FC00000, 32'h40400000}, {32'hBF800000, 32'h3F800000},
              1'b1, 2'd0, 5'h0, {32'hBF000000, 32'hC0E00000}, 5'h00, "R8 pair clean");
        issue({32'h7F800000, 32'h40000000}, {32'h0, 32'h40400000}, {32'h0, 32'h3F800000},
              1'b0, 2'd0, 5'h0, {32'h0, 32'hC0E00000}, 5'h00, "R8 single ignores upper");
        // R9 enable on another cause: no trap, flags accumulate
        issue({32'h0, 32'h7F000000}, {32'h0, 32'h40000000}, 64'h0, 1'b0, 2'd0, 5'h08,
              {32'h0, 32'hFF800000}, 5'h05, "R9 flags accumulate");
        // R10 enabled invalid traps
        issue({32'h0, 32'h7F800000}, {32'h0, 32'h0}, {32'h0, 32'h3F800000}, 1'b0, 2'd0, 5'h08,
              {32'h0, 32'h7FC00000}, 5'h08, "R10 trap invalid");
        idle();
        repeat (6) @(negedge clk);
        checks++;
        if (sb.size() != 0) begin
            fails++;
            $display("FAIL R1 missing done: actual %0d pending expected 0", sb.size());
        end
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule